// File: doc/BRIEF.md
# Multi-Coincidence Serial Frame Receiver

This receiver listens to a single-wire line that idles high and carries a word that is sent again and again. Each bit is coded as the width of a low pulse. A longer low pulse marks the start of each frame. The receiver measures every low pulse in clock ticks and sorts it into a zero, a one or a start mark. It then builds each frame into a data word, MSB first.

A decoded word does not reach the parallel output at once. It must first arrive identically in consecutive frames, 2 times or 4 times as set by a select pin. When that count is reached, the word is compared with the output register. The output is written only if the word differs from it. In both cases the coincidence count starts over.

Three conditions mark the line as disturbed: no start mark for too long, a line held low too long, or a pulse that does not fit its place in the frame. When the line is disturbed, the receiver clears the output and coincidence state and raises a fault flag. The flag stays up until a complete valid frame arrives.

Top module: `multi_coinc_rx`

## Requirements
- R1: After synchronous reset, `word_o` is 0, `fault_o` is 0 and the coincidence count is empty.
- R2: With U = `UNIT` clock ticks, a low pulse of width w decodes as a 0 bit when 1 ≤ w ≤ 2U, as a 1 bit when 2U < w ≤ 4U, and as a start mark when 4U < w ≤ 8U. The `WIDTH` bit pulses that follow a start mark form one word, first bit received in the MSB.
- R3: With `sel4_i` = 0, a word that arrives in 2 consecutive frames is written to `word_o` if it differs from `word_o`.
- R4: With `sel4_i` = 1, 4 consecutive identical frames are needed, and `word_o` does not change after 1, 2 or 3 of them.
- R5: A word that differs from the previous decoded word becomes the new reference, and the count restarts at 1.
- R6: `word_o` changes only as the result of a completed coincidence run or a line fault.
- R7: When a completed run carries the value already in `word_o`, the output is unchanged and the count restarts from empty.
- R8: If no start mark is decoded for 2·`FRAME_UNITS`·U ticks, the receiver raises `fault_o` and clears `word_o`.
- R9: A low level longer than 8U ticks raises `fault_o` and clears `word_o` while the line is still low.
- R10: A bit pulse outside a frame, or a start mark inside an unfinished frame, raises `fault_o` and clears `word_o`. In the second case the new start mark begins a fresh frame.
- R11: `fault_o` drops when the next complete valid word is decoded. That word counts as the first of a new coincidence run.
- R12: While `fault_o` is high, `word_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Serial line, idles high, asynchronous to clk |
| sel4_i | input | 1 | 0: two matching frames needed, 1: four |
| word_o | output | WIDTH | Output memory holding the accepted word |
| fault_o | output | 1 | Disturbed-line indication |

## Verification
The assertions check on every clock that the output moves only after a decoded word or a fault event, that the output is zero whenever the fault flag is up, and that the flag drops only on a decoded word. They also check that each low pulse produces exactly one classification and that the coincidence count never reaches four. Only the bench scenarios can show the rest: the pulse-width thresholds, the 2 and 4 run lengths, the restart after a mismatch, the no-write case for an equal word, and each of the three kinds of line disturbance. For these the bench drives real pulse trains and compares the results with its own frame-level model.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

    typedef enum logic [1:0] {
        PK_NONE  = 2'd0,
        PK_ZERO  = 2'd1,
        PK_ONE   = 2'd2,
        PK_START = 2'd3
    } pulse_kind_e;

    typedef struct packed {
        pulse_kind_e kind;
        logic        stuck;
        logic        timeout;
    } pulse_evt_t;

    localparam int unsigned NEED_LO = 2;
    localparam int unsigned NEED_HI = 4;

    // Sort a finished low pulse of w ticks by its width in units of u ticks.
    function automatic pulse_kind_e classify(input int unsigned w, input int unsigned u);
        if (w == 0)          return PK_NONE;
        else if (w <= 2 * u) return PK_ZERO;
        else if (w <= 4 * u) return PK_ONE;
        else if (w <= 8 * u) return PK_START;
        else                 return PK_NONE;
    endfunction

endpackage

// File: rtl/mcr_pulse_meter.sv
module mcr_pulse_meter
    import mcr_pkg::*;
#(
    parameter int unsigned UNIT        = 4,
    parameter int unsigned FRAME_UNITS = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_i,
    output pulse_evt_t evt_o
);
    localparam int unsigned START_MAX = 8 * UNIT;
    localparam int unsigned TIMEOUT   = 2 * FRAME_UNITS * UNIT;
    localparam int unsigned LOW_W     = $clog2(START_MAX + 2);
    localparam int unsigned IDLE_W    = $clog2(TIMEOUT);

    logic              sync1, sync2;
    logic [LOW_W-1:0]  low_cnt;
    logic [IDLE_W-1:0] idle_cnt;
    pulse_kind_e       kind_now;
    logic              rise;

    assign rise     = sync2 && (low_cnt != '0);
    assign kind_now = rise ? classify(32'(low_cnt), UNIT) : PK_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1    <= 1'b1;
            sync2    <= 1'b1;
            low_cnt  <= '0;
            idle_cnt <= '0;
            evt_o    <= '0;
        end else begin
            sync1         <= line_i;
            sync2         <= sync1;
            evt_o.kind    <= kind_now;
            evt_o.stuck   <= 1'b0;
            evt_o.timeout <= 1'b0;
            if (!sync2) begin
                if (low_cnt <= LOW_W'(START_MAX))
                    low_cnt <= low_cnt + 1'b1;
                if (low_cnt == LOW_W'(START_MAX))
                    evt_o.stuck <= 1'b1;
            end else begin
                low_cnt <= '0;
            end
            if (kind_now == PK_START) begin
                idle_cnt <= '0;
            end else if (idle_cnt == IDLE_W'(TIMEOUT - 1)) begin
                idle_cnt      <= '0;
                evt_o.timeout <= 1'b1;
            end else begin
                idle_cnt <= idle_cnt + 1'b1;
            end
        end
    end

    // R2: a low pulse yields one classification, never two in a row
    a_r2_one_event_per_pulse: assert property (@(posedge clk) disable iff (rst)
        (evt_o.kind != PK_NONE) |=> (evt_o.kind == PK_NONE));

    // R9: a held-low line is reported once per low period
    a_r9_stuck_once: assert property (@(posedge clk) disable iff (rst)
        evt_o.stuck |=> !evt_o.stuck);

endmodule

// File: rtl/mcr_frame_asm.sv
module mcr_frame_asm
    import mcr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  pulse_evt_t       evt_i,
    output logic [WIDTH-1:0] word_o,
    output logic             word_valid_o,
    output logic             fault_evt_o
);
    localparam int unsigned BC_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    logic             in_frame;
    logic [BC_W-1:0]  bit_cnt;
    logic [WIDTH-1:0] shreg;
    logic             bit_val;

    assign bit_val = (evt_i.kind == PK_ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame     <= 1'b0;
            bit_cnt      <= '0;
            shreg        <= '0;
            word_o       <= '0;
            word_valid_o <= 1'b0;
            fault_evt_o  <= 1'b0;
        end else begin
            word_valid_o <= 1'b0;
            fault_evt_o  <= 1'b0;
            case (evt_i.kind)
                PK_START: begin
                    if (in_frame) fault_evt_o <= 1'b1;
                    in_frame <= 1'b1;
                    bit_cnt  <= '0;
                end
                PK_ZERO, PK_ONE: begin
                    if (!in_frame) begin
                        fault_evt_o <= 1'b1;
                    end else begin
                        shreg <= {shreg[WIDTH-2:0], bit_val};
                        if (bit_cnt == BC_W'(WIDTH - 1)) begin
                            word_o       <= {shreg[WIDTH-2:0], bit_val};
                            word_valid_o <= 1'b1;
                            in_frame     <= 1'b0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
            if (evt_i.stuck || evt_i.timeout) begin
                fault_evt_o <= 1'b1;
                in_frame    <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mcr_coinc_filter.sv
module mcr_coinc_filter
    import mcr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel4_i,
    input  logic [WIDTH-1:0] word_i,
    input  logic             valid_i,
    input  logic             fault_evt_i,
    output logic [WIDTH-1:0] out_o,
    output logic             fault_o
);
    logic [WIDTH-1:0] ref_q;
    logic [2:0]       cnt_q;
    logic [2:0]       cnt_next;
    logic [2:0]       need;

    assign need = sel4_i ? 3'(NEED_HI) : 3'(NEED_LO);

    always_comb begin
        if (cnt_q == '0 || word_i != ref_q) cnt_next = 3'd1;
        else                                cnt_next = cnt_q + 3'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q   <= '0;
            cnt_q   <= '0;
            out_o   <= '0;
            fault_o <= 1'b0;
        end else if (fault_evt_i) begin
            cnt_q   <= '0;
            out_o   <= '0;
            fault_o <= 1'b1;
        end else if (valid_i) begin
            fault_o <= 1'b0;
            ref_q   <= word_i;
            if (cnt_next >= need) begin
                cnt_q <= '0;
                if (word_i != out_o) out_o <= word_i;
            end else begin
                cnt_q <= cnt_next;
            end
        end
    end

    // R6: the output moves only after a decoded word or a fault event
    a_r6_out_moves_on_event: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_o) |-> $past(valid_i || fault_evt_i));

    // R12: a raised fault flag always comes with a cleared output
    a_r12_fault_clears_out: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> (out_o == '0));

    // R11: the fault flag drops only on a decoded word
    a_r11_fault_drop_on_word: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_o) |-> $past(valid_i));

    // R4: the stored count never reaches the largest run length
    a_r4_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt_q < 3'(NEED_HI));

endmodule

// File: rtl/multi_coinc_rx.sv
module multi_coinc_rx
    import mcr_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned UNIT        = 4,
    parameter int unsigned FRAME_UNITS = 60
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_i,
    input  logic             sel4_i,
    output logic [WIDTH-1:0] word_o,
    output logic             fault_o
);
    pulse_evt_t       evt;
    logic [WIDTH-1:0] dec_word;
    logic             dec_valid;
    logic             fault_evt;

    mcr_pulse_meter #(.UNIT(UNIT), .FRAME_UNITS(FRAME_UNITS)) u_meter (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_i),
        .evt_o  (evt)
    );

    mcr_frame_asm #(.WIDTH(WIDTH)) u_asm (
        .clk          (clk),
        .rst          (rst),
        .evt_i        (evt),
        .word_o       (dec_word),
        .word_valid_o (dec_valid),
        .fault_evt_o  (fault_evt)
    );

    mcr_coinc_filter #(.WIDTH(WIDTH)) u_filter (
        .clk         (clk),
        .rst         (rst),
        .sel4_i      (sel4_i),
        .word_i      (dec_word),
        .valid_i     (dec_valid),
        .fault_evt_i (fault_evt),
        .out_o       (word_o),
        .fault_o     (fault_o)
    );

endmodule

// File: tb/multi_coinc_rx_tb.sv
module multi_coinc_rx_tb;
    localparam int U = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_i = 1'b1;
    logic       sel4_i = 1'b0;
    logic [7:0] word_o;
    logic       fault_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    // frame-level reference model
    int m_out = 0, m_ref = 0, m_cnt = 0, m_fault = 0;

    always #2.5 clk = ~clk;

    multi_coinc_rx #(.WIDTH(8), .UNIT(U), .FRAME_UNITS(60)) u_dut (
        .clk(clk), .rst(rst), .line_i(line_i), .sel4_i(sel4_i),
        .word_o(word_o), .fault_o(fault_o)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, int'(word_o), m_out);
        chk(req, int'(fault_o), m_fault);
    endtask

    task automatic drive(input logic v, input int units);
        line_i = v;
        repeat (units * U) @(negedge clk);
    endtask

    task automatic model_fault();
        m_out = 0; m_cnt = 0; m_fault = 1;
    endtask

    task automatic model_word(input int w);
        int need;
        need = sel4_i ? 4 : 2;
        m_fault = 0;
        if (m_cnt == 0 || w != m_ref) m_cnt = 1;
        else m_cnt = m_cnt + 1;
        m_ref = w;
        if (m_cnt >= need) begin
            m_cnt = 0;
            m_out = w;
        end
    endtask

    task automatic send_bits(input int w, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) begin
            if (w[i]) begin drive(1'b0, 3); drive(1'b1, 1); end
            else      begin drive(1'b0, 1); drive(1'b1, 3); end
        end
    endtask

    task automatic send_frame(input int w);
        drive(1'b0, 6); drive(1'b1, 2);
        send_bits(w, 7, 0);
        drive(1'b1, 20);
        model_word(w);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 reset state");

        // R4: four-frame mode, no update after 1..3 frames
        sel4_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            send_frame(8'hA5);
            check_all("R4 partial run");
        end
        send_frame(8'hA5);
        check_all("R4 four matches");
        chk("R2 decode A5", int'(word_o), 8'hA5);

        // R3: two-frame mode
        sel4_i = 1'b0;
        send_frame(8'h3C);
        check_all("R3 one frame");
        send_frame(8'h3C);
        check_all("R3 two matches");

        // R5: alternating words never complete a run
        send_frame(8'h81); check_all("R5 alt");
        send_frame(8'h7E); check_all("R5 alt");
        send_frame(8'h81); check_all("R5 alt");
        send_frame(8'h7E); check_all("R5 alt");
        send_frame(8'h7E); check_all("R5 new reference");

        // R7: equal run leaves output alone and restarts the count
        sel4_i = 1'b1;
        for (int k = 0; k < 4; k++) send_frame(8'h7E);
        check_all("R7 equal run");
        send_frame(8'h55); check_all("R7 restart");
        send_frame(8'h55); send_frame(8'h55); check_all("R7 restart");
        send_frame(8'h55); check_all("R7 update after restart");
        chk("R6 output after run", int'(word_o), 8'h55);

        // R8: silent line
        sel4_i = 1'b0;
        drive(1'b1, 130);
        model_fault();
        check_all("R8 timeout");
        chk("R12 output zero in fault", int'(word_o), 0);

        // R11: valid frame clears fault, output waits for coincidence
        send_frame(8'h0F); check_all("R11 fault cleared");
        send_frame(8'h0F); check_all("R11 run after fault");

        // R10: bit pulse outside a frame
        drive(1'b0, 1); drive(1'b1, 20);
        model_fault();
        check_all("R10 stray bit");
        send_frame(8'h0F); check_all("R11 recover");

        // R10: start mark inside an unfinished frame
        drive(1'b0, 6); drive(1'b1, 2);
        send_bits(8'hFF, 7, 5);
        drive(1'b0, 6); drive(1'b1, 2);
        model_fault();
        check_all("R10 restart mid frame");
        send_bits(8'h0F, 7, 0);
        drive(1'b1, 20);
        model_word(8'h0F);
        check_all("R10 fresh frame accepted");
        send_frame(8'h0F); check_all("R10 run after restart");

        // R9: line held low
        drive(1'b0, 10);
        model_fault();
        check_all("R9 stuck low");
        drive(1'b1, 20);
        check_all("R9 after release");

        // R2: all-ones and all-zeros words
        send_frame(8'hFF); send_frame(8'hFF); check_all("R2 word FF");
        send_frame(8'h00); send_frame(8'h00); check_all("R2 word 00");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule